// File: doc/BRIEF.md
# Clock Stop Controller with Synchronized Glitch-Free Gating

This block sits after the clock generator and produces two families of clock outputs from two internal free-running sources: a fast processor clock and a slower peripheral-bus clock. Each family has its own active-low stop request, which power-management logic may change at any time. Dropping a request parks every output of that family at logic low. Raising it again lets the family resume. A stopped or restarted output never shows a shortened high or low phase.

The request for the processor family is asynchronous to the fast clock. It passes through a flop synchronizer clocked by the fast clock and then reaches an enable flop that updates on the falling edge. The bus-family request changes on the rising edge of the ungated bus output, so it is sampled directly by the falling-edge enable flop. This keeps that family's latency within one bus cycle. A dedicated bus-clock output is never gated and serves as the timing reference for driving both requests. Stopping one family leaves the other family and the free output toggling.

Top module: `clk_stop_ctrl`

## Requirements
- R1: While rst_ni is low, every gated output toggles with its source clock whatever the stop inputs are. After reset is released with both stop inputs high (1 = run), all outputs keep toggling.
- R2: bus_free_clk_o always equals bus_clk_i, in reset and whether or not either family is stopped.
- R3: fast_stop_ni is active low (0 = stop). After it falls between two fast rising edges, the outputs still produce full pulses on the next two fast rising edges. From the third edge on they stay low, which is less than 4 fast cycles.
- R4: After fast_stop_ni rises between two fast rising edges, the outputs stay low on the next two fast rising edges. The first pulse appears on the third edge, which is less than 4 fast cycles.
- R5: bus_stop_ni is active low (0 = stop) and changes just after a bus rising edge. No gated bus pulse appears on the next bus rising edge or any later one while the request is low, which is less than 2 bus cycles.
- R6: After bus_stop_ni rises just after a bus rising edge, the gated bus outputs produce a full pulse on the very next bus rising edge.
- R7: Stopping either family does not alter the pulse count of the other family or of the free output. With both families stopped, the free output still toggles.
- R8: While a family is stopped, all of its outputs read low on every sample, including during the high phase of the source. All copies within a family are always equal.
- R9: Every gated high pulse begins on a source rising edge and lasts exactly one source high phase. No gated low phase is shorter than the source low phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fast_clk_i | input | 1 | Free-running processor-rate source clock |
| bus_clk_i | input | 1 | Free-running peripheral-bus source clock |
| rst_ni | input | 1 | Asynchronous active-low reset; forces all families to run |
| fast_stop_ni | input | 1 | Active-low stop request for the processor family, asynchronous |
| bus_stop_ni | input | 1 | Active-low stop request for the gated bus family, changed on bus rising edges |
| fast_clk_o | output | FAST_OUTS (4) | Gated processor clock copies |
| bus_clk_o | output | BUS_OUTS (5) | Gated bus clock copies |
| bus_free_clk_o | output | 1 | Ungated bus clock reference |

## Verification
The processor request is swept across five phase offsets within a fast period and three hold lengths. This separates a synchronizer that is one stage short or long, because the pulse count before the halt shifts, from an enable that updates on the wrong edge, which the pulse-width monitor catches. The bus request is held for one to four bus cycles to pin its one-cycle stop and restart latency. A run with both families stopped at once, and a reset run with both requests low, show that the free output and the other family stay unaffected and that reset overrides a stop.

// File: rtl/clk_stop_pkg.sv
`timescale 1ns/1ps
package clk_stop_pkg;
  localparam int unsigned FAST_OUTS_DEF  = 4;
  localparam int unsigned BUS_OUTS_DEF   = 5;
  localparam int unsigned FAST_SYNC_DEF  = 2;
  localparam int unsigned BUS_SYNC_DEF   = 0;

  typedef enum logic {
    GATE_HALT = 1'b0,
    GATE_RUN  = 1'b1
  } gate_state_e;
endpackage

// File: rtl/clk_stop_sync.sv
`timescale 1ns/1ps
module clk_stop_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= {STAGES{RST_VAL}};
    end else begin
      pipe_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) pipe_q[i] <= pipe_q[i-1];
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/clk_stop_gate.sv
`timescale 1ns/1ps
module clk_stop_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic clk_o
);
  // en_i only changes while clk_i is low
  assign clk_o = clk_i & en_i;
endmodule

// File: rtl/clk_stop_group.sv
`timescale 1ns/1ps
module clk_stop_group
  import clk_stop_pkg::*;
#(
  parameter int unsigned N_OUT       = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_req_i,
  output logic [N_OUT-1:0] clk_o
);
  logic run_sync;
  logic en_q;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      // request already launched from a rising edge of this clock
      assign run_sync = run_req_i;
    end else begin : g_sync
      clk_stop_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
      ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .d_i    (run_req_i),
        .q_o    (run_sync)
      );
    end
  endgenerate

  // falling-edge update keeps enable changes in the low phase
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= logic'(GATE_RUN);
    else         en_q <= run_sync;
  end

  generate
    for (genvar g = 0; g < N_OUT; g++) begin : g_out
      clk_stop_gate u_gate (
        .clk_i (clk_i),
        .en_i  (en_q),
        .clk_o (clk_o[g])
      );
    end
  endgenerate
endmodule

// File: rtl/clk_stop_ctrl.sv
`timescale 1ns/1ps
module clk_stop_ctrl
  import clk_stop_pkg::*;
#(
  parameter int unsigned FAST_OUTS        = FAST_OUTS_DEF,
  parameter int unsigned BUS_OUTS         = BUS_OUTS_DEF,
  parameter int unsigned FAST_SYNC_STAGES = FAST_SYNC_DEF,
  parameter int unsigned BUS_SYNC_STAGES  = BUS_SYNC_DEF
) (
  input  logic                 fast_clk_i,
  input  logic                 bus_clk_i,
  input  logic                 rst_ni,
  input  logic                 fast_stop_ni,
  input  logic                 bus_stop_ni,
  output logic [FAST_OUTS-1:0] fast_clk_o,
  output logic [BUS_OUTS-1:0]  bus_clk_o,
  output logic                 bus_free_clk_o
);
  clk_stop_group #(
    .N_OUT       (FAST_OUTS),
    .SYNC_STAGES (FAST_SYNC_STAGES)
  ) u_fast (
    .clk_i     (fast_clk_i),
    .rst_ni    (rst_ni),
    .run_req_i (fast_stop_ni),
    .clk_o     (fast_clk_o)
  );

  clk_stop_group #(
    .N_OUT       (BUS_OUTS),
    .SYNC_STAGES (BUS_SYNC_STAGES)
  ) u_bus (
    .clk_i     (bus_clk_i),
    .rst_ni    (rst_ni),
    .run_req_i (bus_stop_ni),
    .clk_o     (bus_clk_o)
  );

  assign bus_free_clk_o = bus_clk_i;
endmodule

// File: rtl/clk_stop_ctrl_chk.sv
`timescale 1ns/1ps
module clk_stop_ctrl_chk #(
  parameter int unsigned FAST_OUTS        = 4,
  parameter int unsigned BUS_OUTS         = 5,
  parameter int unsigned FAST_SYNC_STAGES = 2,
  parameter int unsigned BUS_SYNC_STAGES  = 0
) (
  input logic                 fast_clk_i,
  input logic                 bus_clk_i,
  input logic                 rst_ni,
  input logic                 fast_stop_ni,
  input logic                 bus_stop_ni,
  input logic [FAST_OUTS-1:0] fast_clk_o,
  input logic [BUS_OUTS-1:0]  bus_clk_o,
  input logic                 bus_free_clk_o
);
  localparam logic [3:0] F_THR = 4'(FAST_SYNC_STAGES + 1);
  localparam logic [3:0] B_THR = 4'(BUS_SYNC_STAGES + 1);

  // consecutive falling-edge samples of each request level, saturating
  logic [3:0] f_lo_cnt, f_hi_cnt, b_lo_cnt, b_hi_cnt;

  always_ff @(negedge fast_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      f_lo_cnt <= '0;
      f_hi_cnt <= '0;
    end else begin
      f_lo_cnt <= fast_stop_ni ? 4'd0 : ((f_lo_cnt == 4'hf) ? f_lo_cnt : f_lo_cnt + 4'd1);
      f_hi_cnt <= !fast_stop_ni ? 4'd0 : ((f_hi_cnt == 4'hf) ? f_hi_cnt : f_hi_cnt + 4'd1);
    end
  end

  always_ff @(negedge bus_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      b_lo_cnt <= '0;
      b_hi_cnt <= '0;
    end else begin
      b_lo_cnt <= bus_stop_ni ? 4'd0 : ((b_lo_cnt == 4'hf) ? b_lo_cnt : b_lo_cnt + 4'd1);
      b_hi_cnt <= !bus_stop_ni ? 4'd0 : ((b_hi_cnt == 4'hf) ? b_hi_cnt : b_hi_cnt + 4'd1);
    end
  end

  p_free_high_r2: assert property (@(negedge bus_clk_i) disable iff (!rst_ni)
    bus_free_clk_o);
  p_free_low_r2: assert property (@(posedge bus_clk_i) disable iff (!rst_ni)
    !bus_free_clk_o);
  p_fast_halt_r3: assert property (@(negedge fast_clk_i) disable iff (!rst_ni)
    (f_lo_cnt >= F_THR) |-> (fast_clk_o == '0));
  p_fast_resume_r4: assert property (@(negedge fast_clk_i) disable iff (!rst_ni)
    (f_hi_cnt >= F_THR) |-> (fast_clk_o == '1));
  p_bus_halt_r5: assert property (@(negedge bus_clk_i) disable iff (!rst_ni)
    (b_lo_cnt >= B_THR) |-> (bus_clk_o == '0));
  p_bus_resume_r6: assert property (@(negedge bus_clk_i) disable iff (!rst_ni)
    (b_hi_cnt >= B_THR) |-> (bus_clk_o == '1));
  p_fast_copies_r8: assert property (@(negedge fast_clk_i) disable iff (!rst_ni)
    ($countones(fast_clk_o) == 0) || ($countones(fast_clk_o) == FAST_OUTS));
  p_bus_copies_r8: assert property (@(negedge bus_clk_i) disable iff (!rst_ni)
    ($countones(bus_clk_o) == 0) || ($countones(bus_clk_o) == BUS_OUTS));
  p_fast_low_phase_r9: assert property (@(posedge fast_clk_i) disable iff (!rst_ni)
    1'b1 |-> ($countones(fast_clk_o) == 0));
endmodule

bind clk_stop_ctrl clk_stop_ctrl_chk #(
  .FAST_OUTS        (FAST_OUTS),
  .BUS_OUTS         (BUS_OUTS),
  .FAST_SYNC_STAGES (FAST_SYNC_STAGES),
  .BUS_SYNC_STAGES  (BUS_SYNC_STAGES)
) u_chk (
  .fast_clk_i     (fast_clk_i),
  .bus_clk_i      (bus_clk_i),
  .rst_ni         (rst_ni),
  .fast_stop_ni   (fast_stop_ni),
  .bus_stop_ni    (bus_stop_ni),
  .fast_clk_o     (fast_clk_o),
  .bus_clk_o      (bus_clk_o),
  .bus_free_clk_o (bus_free_clk_o)
);

// File: tb/clk_stop_ctrl_bench.sv
`timescale 1ns/1ps
module clk_stop_ctrl_bench;
  import clk_stop_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int BUS_PERIOD = 3 * CLK_PERIOD;
  localparam int NF = FAST_OUTS_DEF;
  localparam int NB = BUS_OUTS_DEF;
  localparam logic [NF-1:0] F_ON = {NF{1'b1}};
  localparam logic [NB-1:0] B_ON = {NB{1'b1}};

  logic          fast_clk_i = 1'b0;
  logic          bus_clk_i  = 1'b0;
  logic          rst_ni     = 1'b0;
  logic          fast_stop_ni = 1'b0;
  logic          bus_stop_ni  = 1'b0;
  logic [NF-1:0] fast_clk_o;
  logic [NB-1:0] bus_clk_o;
  logic          bus_free_clk_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) fast_clk_i = ~fast_clk_i;
  always #(BUS_PERIOD/2) bus_clk_i  = ~bus_clk_i;

  clk_stop_ctrl u_clk_stop_ctrl (
    .fast_clk_i     (fast_clk_i),
    .bus_clk_i      (bus_clk_i),
    .rst_ni         (rst_ni),
    .fast_stop_ni   (fast_stop_ni),
    .bus_stop_ni    (bus_stop_ni),
    .fast_clk_o     (fast_clk_o),
    .bus_clk_o      (bus_clk_o),
    .bus_free_clk_o (bus_free_clk_o)
  );

  longint fast_out_cnt = 0, bus_out_cnt = 0, free_cnt = 0;
  longint fast_src_cnt = 0, bus_src_cnt = 0;
  always @(posedge fast_clk_i)     fast_src_cnt++;
  always @(posedge bus_clk_i)      bus_src_cnt++;
  always @(posedge fast_clk_o[0])  fast_out_cnt++;
  always @(posedge bus_clk_o[0])   bus_out_cnt++;
  always @(posedge bus_free_clk_o) free_cnt++;

  // pulse-shape monitors (R9)
  int fast_runt = 0, bus_runt = 0;
  longint f_rise_t = 0, f_fall_t = 0, b_rise_t = 0, b_fall_t = 0;
  bit f_seen_rise = 0, f_seen_fall = 0, b_seen_rise = 0, b_seen_fall = 0;

  always @(posedge fast_clk_o[0]) begin
    if (($time % CLK_PERIOD) != CLK_PERIOD/2) fast_runt++;
    if (f_seen_fall && (($time - f_fall_t) < CLK_PERIOD/2)) fast_runt++;
    f_rise_t = $time;
    f_seen_rise = 1;
  end
  always @(negedge fast_clk_o[0]) begin
    if (f_seen_rise && (($time - f_rise_t) != CLK_PERIOD/2)) fast_runt++;
    f_fall_t = $time;
    f_seen_fall = f_seen_rise;
  end
  always @(posedge bus_clk_o[0]) begin
    if (($time % BUS_PERIOD) != BUS_PERIOD/2) bus_runt++;
    if (b_seen_fall && (($time - b_fall_t) < BUS_PERIOD/2)) bus_runt++;
    b_rise_t = $time;
    b_seen_rise = 1;
  end
  always @(negedge bus_clk_o[0]) begin
    if (b_seen_rise && (($time - b_rise_t) != BUS_PERIOD/2)) bus_runt++;
    b_fall_t = $time;
    b_seen_fall = b_seen_rise;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic fast_case(input int h, input int o);
    longint f0, bs0, bo0, fr0;
    @(posedge fast_clk_i); #(o);
    f0 = fast_out_cnt; bs0 = bus_src_cnt; bo0 = bus_out_cnt; fr0 = free_cnt;
    fast_stop_ni = 1'b0;
    repeat (2) @(posedge fast_clk_i);
    #1 check(fast_clk_o == F_ON, "R3 second edge still pulses", longint'(fast_clk_o), longint'(F_ON));
    @(posedge fast_clk_i);
    #1 check(fast_clk_o == '0, "R3 halted at third edge", longint'(fast_clk_o), 0);
    check(fast_out_cnt - f0 == 2, "R3 pulses before halt", fast_out_cnt - f0, 2);
    repeat (3*h) @(posedge fast_clk_i);
    #1 check(fast_clk_o == '0, "R8 held low", longint'(fast_clk_o), 0);
    check(fast_out_cnt - f0 == 2, "R8 no pulse while stopped", fast_out_cnt - f0, 2);
    check(bus_out_cnt - bo0 == bus_src_cnt - bs0, "R7 bus family unaffected", bus_out_cnt - bo0, bus_src_cnt - bs0);
    check(free_cnt - fr0 == bus_src_cnt - bs0, "R2 free output runs", free_cnt - fr0, bus_src_cnt - bs0);
    @(posedge fast_clk_i); #(o);
    fast_stop_ni = 1'b1;
    f0 = fast_out_cnt;
    repeat (2) @(posedge fast_clk_i);
    #1 check(fast_clk_o == '0 && fast_out_cnt == f0, "R4 no early pulse", fast_out_cnt - f0, 0);
    @(posedge fast_clk_i);
    #1 check(fast_clk_o == F_ON, "R4 resumes on third edge", longint'(fast_clk_o), longint'(F_ON));
    check(fast_out_cnt - f0 == 1, "R4 one pulse after resume", fast_out_cnt - f0, 1);
  endtask

  task automatic bus_case(input int h);
    longint b0, fs0, fo0;
    @(posedge bus_clk_i); #1;
    b0 = bus_out_cnt; fs0 = fast_src_cnt; fo0 = fast_out_cnt;
    bus_stop_ni = 1'b0;
    for (int i = 0; i < h; i++) begin
      @(posedge bus_clk_i);
      #1 check(bus_clk_o == '0, (i == 0) ? "R5 halted on next edge" : "R8 bus held low",
               longint'(bus_clk_o), 0);
    end
    check(bus_out_cnt - b0 == 0, "R5 no bus pulse while stopped", bus_out_cnt - b0, 0);
    check(fast_out_cnt - fo0 == fast_src_cnt - fs0, "R7 fast family unaffected", fast_out_cnt - fo0, fast_src_cnt - fs0);
    check(bus_free_clk_o == 1'b1, "R2 free high after edge", longint'(bus_free_clk_o), 1);
    bus_stop_ni = 1'b1;
    b0 = bus_out_cnt;
    @(posedge bus_clk_i);
    #1 check(bus_clk_o == B_ON, "R6 resumes on next edge", longint'(bus_clk_o), longint'(B_ON));
    check(bus_out_cnt - b0 == 1, "R6 one pulse after resume", bus_out_cnt - b0, 1);
  endtask

  initial begin
    longint f0, b0, fr0;
    // reset with both requests low
    repeat (2) @(posedge bus_clk_i); #1;
    f0 = fast_out_cnt; b0 = bus_out_cnt; fr0 = free_cnt;
    repeat (3) @(posedge bus_clk_i); #1;
    check(fast_out_cnt - f0 == 9, "R1 fast runs in reset", fast_out_cnt - f0, 9);
    check(bus_out_cnt - b0 == 3, "R1 bus runs in reset", bus_out_cnt - b0, 3);
    check(free_cnt - fr0 == 3, "R2 free runs in reset", free_cnt - fr0, 3);
    fast_stop_ni = 1'b1;
    bus_stop_ni  = 1'b1;
    repeat (2) @(posedge bus_clk_i); #1;
    rst_ni = 1'b1;
    repeat (2) @(posedge bus_clk_i); #1;
    check(fast_clk_o == F_ON, "R1 fast running after reset", longint'(fast_clk_o), longint'(F_ON));
    check(bus_clk_o == B_ON, "R1 bus running after reset", longint'(bus_clk_o), longint'(B_ON));

    for (int h = 1; h <= 3; h++)
      for (int o = 1; o <= 9; o += 2)
        fast_case(h, o);

    for (int h = 1; h <= 4; h++) bus_case(h);

    // both families stopped together
    @(posedge bus_clk_i); #1;
    fr0 = free_cnt;
    fast_stop_ni = 1'b0;
    bus_stop_ni  = 1'b0;
    repeat (3) @(posedge bus_clk_i); #1;
    check(fast_clk_o == '0 && bus_clk_o == '0, "R7 both families stopped",
          longint'({fast_clk_o, bus_clk_o}), 0);
    check(free_cnt - fr0 == 3, "R7 free runs with both stopped", free_cnt - fr0, 3);
    fast_stop_ni = 1'b1;
    bus_stop_ni  = 1'b1;
    repeat (2) @(posedge bus_clk_i); #1;
    check(fast_clk_o == F_ON && bus_clk_o == B_ON, "R7 both families resumed",
          longint'({fast_clk_o, bus_clk_o}), longint'({F_ON, B_ON}));

    check(fast_runt == 0, "R9 fast pulse shape", fast_runt, 0);
    check(bus_runt == 0, "R9 bus pulse shape", bus_runt, 0);
    check(f_seen_fall && b_seen_fall, "R9 pulses observed", longint'({f_seen_fall, b_seen_fall}), 3);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * CLK_PERIOD);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule